// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block sequences a switching regulator controller from power-off to steady regulation. It combines two supply comparator flags into a lockout with hysteresis. Once the supply is good and the run input is high, it enables the oscillator and bias first. It then waits out a fixed power-on-reset interval. Next it drives a digital soft-start reference that climbs one step at a time from zero to full scale. The modulator is enabled once that ramp passes a programmable level.

The sync-rectifier drive stays tri-stated until the commanded duty value first reaches a threshold. It also stays tri-stated whenever the effective mode is pulse skipping. Start-up always runs in fixed-frequency mode. The external mode pin only takes effect after the ramp has reached full scale. Losing the supply or pulling the run input low returns the machine to off and clears every counter, so the next start repeats the whole sequence. All outputs are registers.

Top module: `pwr_start_seq`

## Requirements
- R1: Lockout releases on a clock edge where `sup_hi` is 1. Once released it stays released while `sup_lo_ok` is 1, even with `sup_hi` at 0. It re-engages only on an edge where `sup_lo_ok` is 0. While engaged, `sup_lo_ok` alone never releases it.
- R2: In reset and while off, the outputs take fixed values: `osc_en`, `drv_en` and `pwm_en` are 0, `ramp` is 0, `sr_tri` is 1 and `mode_eff` is 1.
- R3: One edge after the edge that releases lockout (with `run_req` high), `osc_en` becomes 1. For the next POR_CYC edges, counting that one, `drv_en` stays 0 and `ramp` stays 0.
- R4: On the POR_CYC-th edge after `osc_en` rises, `drv_en` becomes 1. From then on, `ramp` rises by exactly 1 every RAMP_DIV edges and holds at its all-ones value.
- R5: `pwm_en` is 1 exactly when `drv_en` is 1 and `ramp` is at least PWM_THR. It stays 1 once the ramp is full.
- R6: `sr_tri` falls on the edge that samples `pwm_en` = 1 and `duty` >= SR_THR. Before that it is 1, even if `duty` was high earlier. After it falls, it stays 0 when `duty` drops again, as long as the effective mode is PWM.
- R7: `mode_eff` is 1 (PWM) until `ramp` reaches full scale, whatever `mode_sel` is. After that it copies `mode_sel` with one edge of delay (1 = PWM, 0 = pulse skip).
- R8: When `mode_eff` is 0, `sr_tri` is 1. Returning to PWM restores `sr_tri` to 0 if it had already been released.
- R9: `run_req` low on an edge forces the off state of R2 on that same edge. Raising it again restarts from the power-on-reset delay, with the ramp at 0 and `sr_tri` at 1.
- R10: `sup_lo_ok` low on an edge drops the lockout. The outputs reach the off state on the following edge. Recovery needs `sup_hi` and then replays the full delay and ramp from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | 1 = run, 0 = shut down |
| sup_hi | input | 1 | Supply above rising threshold |
| sup_lo_ok | input | 1 | Supply above falling threshold |
| mode_sel | input | 1 | Requested mode, 1 = PWM, 0 = pulse skip |
| duty | input | DUTY_W | Present duty command |
| osc_en | output | 1 | Oscillator and bias enable |
| drv_en | output | 1 | Gate driver enable |
| ramp | output | RAMP_W | Soft-start reference value |
| pwm_en | output | 1 | Modulator enable |
| sr_tri | output | 1 | Sync rectifier held off (tri-state) |
| mode_eff | output | 1 | Effective mode, 1 = PWM |

## Verification
The lockout assertions assume the two supply flags are consistent: `sup_hi` high implies `sup_lo_ok` high. The stimulus never raises the upper flag with the lower one low. The shutdown and supply inputs are taken to be already synchronous to `clk`, so the bench changes them only on falling edges. The duty and mode inputs are also held steady across each rising edge.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_POR  = 2'd1,
    ST_RAMP = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pss_lockout.sv
module pss_lockout (
  input  logic clk,
  input  logic rst,
  input  logic sup_hi,
  input  logic sup_lo_ok,
  output logic ok_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q <= 1'b0;
    end else if (!ok_q && sup_hi) begin
      ok_q <= 1'b1;
    end else if (ok_q && !sup_lo_ok) begin
      ok_q <= 1'b0;
    end
  end

  // R1: release only after an upper-threshold crossing
  a_r1_release_needs_hi : assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> $past(sup_hi));
  // R1: re-engage only after falling below the lower threshold
  a_r1_engage_needs_lo : assert property (@(posedge clk) disable iff (rst)
    $fell(ok_q) |-> !$past(sup_lo_ok));
endmodule

// File: rtl/pss_por_timer.sv
module pss_por_timer #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= done ? '0 : cnt_q + CW'(1);
    end
  end

  // R3: the delay counter never passes its terminal count
  a_r3_cnt_bound : assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/pss_ramp.sv
module pss_ramp #(
  parameter int RAMP_W   = 6,
  parameter int RAMP_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  output logic [RAMP_W-1:0] ramp_q,
  output logic [RAMP_W-1:0] ramp_nxt,
  output logic              full_nxt
);
  localparam logic [RAMP_W-1:0] TOP_M1 = {{(RAMP_W-1){1'b1}}, 1'b0};

  logic step;

  generate
    if (RAMP_DIV == 1) begin : g_nodiv
      assign step = en;
    end else begin : g_div
      localparam int DVW = $clog2(RAMP_DIV);
      localparam logic [DVW-1:0] DLAST = DVW'(RAMP_DIV - 1);
      logic [DVW-1:0] div_q;
      assign step = en && (div_q == DLAST);
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          div_q <= '0;
        end else if (en) begin
          div_q <= step ? '0 : div_q + DVW'(1);
        end
      end
    end
  endgenerate

  assign ramp_nxt = clr ? '0 : ramp_q + {{(RAMP_W-1){1'b0}}, step};
  assign full_nxt = !clr && step && (ramp_q == TOP_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
    end else begin
      ramp_q <= ramp_nxt;
    end
  end

  // R4: ramp moves only by single upward steps or a clear to zero
  a_r4_unit_step : assert property (@(posedge clk) disable iff (rst)
    (!$stable(ramp_q) && (ramp_q != '0)) |-> (ramp_q == $past(ramp_q) + RAMP_W'(1)));
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int RAMP_W  = 6,
  parameter int DUTY_W  = 8,
  parameter int PWM_THR = 12,
  parameter int SR_THR  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_req,
  input  logic              lock_ok,
  input  logic              mode_sel,
  input  logic [DUTY_W-1:0] duty,
  input  logic              por_done,
  input  logic [RAMP_W-1:0] ramp_q,
  input  logic [RAMP_W-1:0] ramp_nxt,
  input  logic              ramp_full_nxt,
  output logic              por_clr,
  output logic              por_en,
  output logic              ramp_clr,
  output logic              ramp_en,
  output logic              osc_en,
  output logic              drv_en,
  output logic              pwm_en,
  output logic              sr_tri,
  output logic              mode_eff
);
  localparam logic [RAMP_W-1:0] THR_V = RAMP_W'(PWM_THR);
  localparam logic [DUTY_W-1:0] SR_V  = DUTY_W'(SR_THR);

  seq_state_t st_q, st_nxt;
  logic active, sr_arm_q, sr_arm_nxt, mode_nxt;

  assign active   = lock_ok && run_req;
  assign por_en   = active && (st_q == ST_POR);
  assign por_clr  = !por_en;
  assign ramp_en  = active && (st_q == ST_RAMP);
  assign ramp_clr = !active || (st_q == ST_OFF) || (st_q == ST_POR);

  always_comb begin
    st_nxt = st_q;
    if (!active) begin
      st_nxt = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  st_nxt = ST_POR;
        ST_POR:  st_nxt = por_done ? ST_RAMP : ST_POR;
        ST_RAMP: st_nxt = ramp_full_nxt ? ST_RUN : ST_RAMP;
        default: st_nxt = ST_RUN;
      endcase
    end
  end

  assign sr_arm_nxt = (st_nxt != ST_OFF) && (sr_arm_q || (pwm_en && (duty >= SR_V)));
  assign mode_nxt   = (st_nxt == ST_RUN) ? mode_sel : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      sr_arm_q <= 1'b0;
      osc_en   <= 1'b0;
      drv_en   <= 1'b0;
      pwm_en   <= 1'b0;
      sr_tri   <= 1'b1;
      mode_eff <= 1'b1;
    end else begin
      st_q     <= st_nxt;
      sr_arm_q <= sr_arm_nxt;
      osc_en   <= (st_nxt != ST_OFF);
      drv_en   <= (st_nxt == ST_RAMP) || (st_nxt == ST_RUN);
      pwm_en   <= (st_nxt == ST_RUN) || ((st_nxt == ST_RAMP) && (ramp_nxt >= THR_V));
      sr_tri   <= !(sr_arm_nxt && mode_nxt);
      mode_eff <= mode_nxt;
    end
  end

  // R2: nothing switches while the bias is off
  a_r2_off_quiet : assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!drv_en && !pwm_en && sr_tri));
  // R3: drivers stay off during the power-on-reset wait
  a_r3_no_drv_in_por : assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POR) |-> !drv_en);
  // R5: modulator enabled only at or above the ramp threshold
  a_r5_pwm_thr : assert property (@(posedge clk) disable iff (rst)
    pwm_en |-> (ramp_q >= THR_V));
  // R6: rectifier released only with the modulator running in PWM
  a_r6_release_cond : assert property (@(posedge clk) disable iff (rst)
    $fell(sr_tri) |-> (pwm_en && mode_eff));
  // R7: pulse skipping never appears before start-up completes
  a_r7_pwm_in_start : assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |-> mode_eff);
  // R9: shutdown drops the bias on the next edge
  a_r9_shutdown : assert property (@(posedge clk) disable iff (rst)
    !run_req |=> !osc_en);
endmodule

// File: rtl/pwr_start_seq.sv
module pwr_start_seq #(
  parameter int POR_CYC  = 16,
  parameter int RAMP_W   = 6,
  parameter int RAMP_DIV = 4,
  parameter int PWM_THR  = 12,
  parameter int DUTY_W   = 8,
  parameter int SR_THR   = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_req,
  input  logic              sup_hi,
  input  logic              sup_lo_ok,
  input  logic              mode_sel,
  input  logic [DUTY_W-1:0] duty,
  output logic              osc_en,
  output logic              drv_en,
  output logic [RAMP_W-1:0] ramp,
  output logic              pwm_en,
  output logic              sr_tri,
  output logic              mode_eff
);
  logic lock_ok, por_done, por_clr, por_en;
  logic ramp_clr, ramp_en, ramp_full_nxt;
  logic [RAMP_W-1:0] ramp_nxt;

  pss_lockout u_lock (
    .clk(clk), .rst(rst), .sup_hi(sup_hi), .sup_lo_ok(sup_lo_ok), .ok_q(lock_ok)
  );

  pss_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst(rst), .clr(por_clr), .en(por_en), .done(por_done)
  );

  pss_ramp #(.RAMP_W(RAMP_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk(clk), .rst(rst), .clr(ramp_clr), .en(ramp_en),
    .ramp_q(ramp), .ramp_nxt(ramp_nxt), .full_nxt(ramp_full_nxt)
  );

  pss_ctrl #(.RAMP_W(RAMP_W), .DUTY_W(DUTY_W), .PWM_THR(PWM_THR), .SR_THR(SR_THR)) u_ctrl (
    .clk(clk), .rst(rst), .run_req(run_req), .lock_ok(lock_ok), .mode_sel(mode_sel),
    .duty(duty), .por_done(por_done), .ramp_q(ramp), .ramp_nxt(ramp_nxt),
    .ramp_full_nxt(ramp_full_nxt), .por_clr(por_clr), .por_en(por_en),
    .ramp_clr(ramp_clr), .ramp_en(ramp_en), .osc_en(osc_en), .drv_en(drv_en),
    .pwm_en(pwm_en), .sr_tri(sr_tri), .mode_eff(mode_eff)
  );
endmodule

// File: tb/sim_pwr_start_seq.sv
module sim_pwr_start_seq;
  localparam int POR = 16;
  localparam int DIV = 4;
  localparam int RW  = 6;
  localparam int TOP = 63;
  localparam int THR = 12;
  localparam int DW  = 8;
  localparam int SRT = 26;

  typedef struct {
    int    edge_no;
    string tag;
    logic [4:0] flags;  // osc, drv, pwm, tri, mode
    int    rmp;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_req = 1'b0, sup_hi = 1'b0, sup_lo_ok = 1'b0, mode_sel = 1'b1;
  logic [DW-1:0] duty = '0;
  logic osc_en, drv_en, pwm_en, sr_tri, mode_eff;
  logic [RW-1:0] ramp;

  int edge_cnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  pwr_start_seq #(.POR_CYC(POR), .RAMP_W(RW), .RAMP_DIV(DIV), .PWM_THR(THR),
                  .DUTY_W(DW), .SR_THR(SRT)) u0 (
    .clk(clk), .rst(rst), .run_req(run_req), .sup_hi(sup_hi), .sup_lo_ok(sup_lo_ok),
    .mode_sel(mode_sel), .duty(duty), .osc_en(osc_en), .drv_en(drv_en), .ramp(ramp),
    .pwm_en(pwm_en), .sr_tri(sr_tri), .mode_eff(mode_eff)
  );

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // monitor: pop expected item and compare after the edge settles
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = sb.pop_front();
      act = {osc_en, drv_en, pwm_en, sr_tri, mode_eff};
      checks++;
      if (e.edge_no != edge_cnt || act !== e.flags || (e.rmp >= 0 && int'(ramp) != e.rmp)) begin
        fails++;
        $display("FAIL %s edge=%0d: actual osc/drv/pwm/tri/mode=%b ramp=%0d expected %b ramp=%0d (edge %0d)",
                 e.tag, edge_cnt, act, ramp, e.flags, e.rmp, e.edge_no);
      end
    end
  end

  task automatic push(string tag, logic [4:0] f, int r);
    exp_t e;
    e.edge_no = edge_cnt + 1;
    e.tag = tag;
    e.flags = f;
    e.rmp = r;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int ramp_at(int j);
    int v;
    if (j < POR) return 0;
    v = (j - POR) / DIV;
    return (v > TOP) ? TOP : v;
  endfunction

  localparam logic [4:0] OFF = 5'b00011;

  // plain start-up window, duty 0 and PWM requested
  task automatic plain_window(string tag, int j0, int j1);
    for (int j = j0; j <= j1; j++) begin
      int r;
      r = ramp_at(j);
      push(tag, {1'b1, j >= POR, (j >= POR) && (r >= THR), 1'b1, 1'b1}, r);
      tick();
    end
  endtask

  initial begin
    tick();
    // R2: reset state
    for (int i = 0; i < 3; i++) begin push("R2 reset", OFF, 0); tick(); end
    rst = 1'b0;
    run_req = 1'b1;
    sup_lo_ok = 1'b1;
    // R1: lower flag alone must not release lockout
    for (int i = 0; i < 3; i++) begin push("R1 no release on lower flag", OFF, 0); tick(); end
    sup_hi = 1'b1;
    push("R1 release edge, still off", OFF, 0); tick();
    sup_hi = 1'b0;
    // Main start-up: R3 R4 R5 R6 R7 R8
    for (int j = 0; j < 300; j++) begin
      int r;
      bit pw, run, md, tri_e, me;
      duty = (j < 30) ? 8'd0 : (j < 81) ? 8'd25 : (j < 150) ? 8'd26 : 8'd0;
      md = !((j >= 200 && j < 260) || (j >= 280 && j < 290));
      mode_sel = md;
      r = ramp_at(j);
      pw = (j >= POR) && (r >= THR);
      run = (j >= POR + TOP * DIV);
      me = run ? md : 1'b1;
      tri_e = !((j >= 81) && me);
      push(j < POR ? "R3 por wait" : (j == 81 ? "R6 duty threshold" :
           (j >= 280 && j < 290 ? "R8 skip forces tri" :
           (j >= 200 && j < 260 ? "R7 mode ignored in ramp" : "R4 R5 ramp"))),
           {1'b1, j >= POR, pw, tri_e, me}, r);
      tick();
    end
    mode_sel = 1'b1;
    duty = '0;
    // R9: shutdown
    run_req = 1'b0;
    for (int i = 0; i < 3; i++) begin push("R9 shutdown off", OFF, 0); tick(); end
    run_req = 1'b1;
    for (int j = 0; j < 30; j++) begin
      int r;
      r = ramp_at(j);
      push("R9 restart", {1'b1, j >= POR, (j >= POR) && (r >= THR), 1'b1, 1'b1}, r);
      tick();
    end
    // R10: drop below lower threshold
    sup_lo_ok = 1'b0;
    push("R10 edge of drop", {1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, ramp_at(30)); tick();
    sup_lo_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin push("R10 R1 stays locked", OFF, 0); tick(); end
    sup_hi = 1'b1;
    push("R10 relock edge", OFF, 0); tick();
    sup_hi = 1'b0;
    plain_window("R10 full replay", 0, 20);
    repeat (3) tick();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule